// File: doc/BRIEF.md
# Delta-Cycle Stabilization Controller

This block runs one simulated system clock cycle of a time-multiplexed simulator. It hands entities one at a time to a shared evaluation unit, each such step being a delta cycle. After each evaluation it takes back two things from that unit: a flag that says whether the entity's link vector changed, and the entity's output vector. When a start request arrives, every entity is marked pending. The controller then serves pending entities from the lowest index upward.

An entity whose outputs pass through chains of asynchronous-read memories is evaluated again and again until it settles. Three stop rules are available. The count rule stops after a configured chain depth. The match rule stops when two back-to-back evaluations in the same round return the same output. The combined rule stops on whichever of the two happens first. When a settled entity's link changed during its round, every entity that its row of the fanout table marks is scheduled again. The system cycle is complete once nothing is pending. Completion gives a one-cycle done pulse, followed on the next cycle by a one-cycle request to swap the old and new state banks. A limit on the total number of evaluations per system cycle guards against loops that never settle.

The state machine has these states:
- IDLE: waits for start.
- PICK: takes the lowest pending entity, or moves to DONE when nothing is pending.
- ISSUE: strobes the evaluation, or moves to FAULT when the limit is used up.
- WAIT: takes the result, then returns to ISSUE when the entity has not settled, or to PICK when it has.
- DONE: pulses cycle completion, then moves to SWAP.
- SWAP: pulses the bank swap request, then returns to IDLE.
- FAULT: sets the error flag and returns to IDLE.

Top module: `delta_settle_ctrl`

## Requirements
- R1: After reset, eval_go, cycle_done, swap_req and budget_err are 0 and eval_idx is 0.
- R2: A start seen in IDLE marks all N_ENT entities pending. Every entity is then evaluated in at least one round, and the first pass visits indices 0 to N_ENT-1 in ascending order.
- R3: eval_go is high for exactly one cycle per evaluation. No new eval_go is raised until eval_done has returned the result of the previous evaluation.
- R4: With stop_mode 2'b00 (count), each round of an entity has exactly cfg_depth evaluations. A cfg_depth of 0 acts as 1.
- R5: With stop_mode 2'b01 (match), a round ends at the first evaluation whose eval_out equals the eval_out of the evaluation just before it in the same round, so a round has at least two evaluations.
- R6: With stop_mode 2'b10 or 2'b11 (combined), a round ends at the earlier of the R4 and R5 stopping points.
- R7: If link_changed is high on any evaluation of a round, then when the round ends every entity j with bit i*N_ENT+j of cfg_fanout set is marked pending, where i is the evaluated entity. The next entity served is always the lowest pending index.
- R8: A round with no link change marks nothing pending. cycle_done is raised only when no entity is pending.
- R9: cycle_done is a single-cycle pulse, and swap_req is a single-cycle pulse in the cycle right after it.
- R10: When MAX_EVALS evaluations have been issued in one system cycle and more are needed, no further eval_go is raised, budget_err goes to 1 and no cycle_done is given. budget_err stays set until the next start clears it.
- R11: A start pulse while a system cycle is in progress has no effect on the evaluation sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a system cycle (honoured only in IDLE) |
| stop_mode | input | 2 | 00 count, 01 match, 10/11 combined |
| cfg_depth | input | DEPTH_W (4) | Chain-depth count for the count rule |
| cfg_fanout | input | N_ENT*N_ENT (64) | Row i, bits i*N_ENT+:N_ENT, lists the entities fed by entity i |
| eval_go | output | 1 | Evaluate strobe to the evaluation unit |
| eval_idx | output | IDX_W (3) | Index of the entity under evaluation |
| eval_done | input | 1 | Result valid from the evaluation unit |
| link_changed | input | 1 | The evaluated entity's link vector changed |
| eval_out | input | OUT_W (16) | Output vector of the evaluated entity |
| cycle_done | output | 1 | System cycle complete pulse |
| swap_req | output | 1 | State-bank swap request pulse |
| budget_err | output | 1 | Evaluation limit reached before stability |

## Verification
Several properties are checked by the assertions on every cycle:
- the evaluate strobe lasts one cycle;
- the entity index holds steady across an evaluation;
- the picker always grants the lowest pending bit;
- completion happens only with an empty pending set, and the swap request follows it;
- no strobe is raised once the limit is spent, and no completion comes with the error.

Other behaviour only the directed scenarios can show. This covers the exact sequence of entity indices under each stop rule, rescheduling through the fanout table in ascending order, the handling of a zero depth, a start ignored while busy, and the error being cleared by a later start.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    typedef enum logic [1:0] {
        STOP_COUNT  = 2'b00,
        STOP_MATCH  = 2'b01,
        STOP_EITHER = 2'b10
    } stop_rule_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_PICK  = 3'd1,
        S_ISSUE = 3'd2,
        S_WAIT  = 3'd3,
        S_DONE  = 3'd4,
        S_SWAP  = 3'd5,
        S_FAULT = 3'd6
    } ctrl_state_e;

endpackage

// File: rtl/dsc_pick_lowest.sv
module dsc_pick_lowest #(
    parameter int N_ENT = 8,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic [N_ENT-1:0] req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
                any = 1'b1;
            end
        end
    end

    logic [N_ENT-1:0] below_mask;
    assign below_mask = (N_ENT'(1) << idx) - N_ENT'(1);

    always_comb begin
        if (any) begin
            AST_PICK_LOWEST: assert (req[idx] && ((req & below_mask) == '0)); // R7
        end
    end

endmodule

// File: rtl/dsc_settle_judge.sv
module dsc_settle_judge #(
    parameter int OUT_W   = 16,
    parameter int DEPTH_W = 4,
    parameter int REP_W   = 8
) (
    input  logic [1:0]         mode,
    input  logic [DEPTH_W-1:0] depth,
    input  logic [REP_W-1:0]   reps,
    input  logic [OUT_W-1:0]   cur_out,
    input  logic [OUT_W-1:0]   prev_out,
    output logic               settled
);
    import dsc_pkg::*;

    logic [DEPTH_W-1:0] eff_depth;
    logic               count_hit;
    logic               match_hit;

    assign eff_depth = (depth == '0) ? DEPTH_W'(1) : depth;
    assign count_hit = (reps >= REP_W'(eff_depth));
    assign match_hit = (reps >= REP_W'(2)) && (cur_out == prev_out);

    always_comb begin
        unique case (mode)
            STOP_COUNT: settled = count_hit;
            STOP_MATCH: settled = match_hit;
            default:    settled = count_hit | match_hit;
        endcase
    end

endmodule

// File: rtl/dsc_eval_budget.sv
module dsc_eval_budget #(
    parameter int MAX_EVALS = 64,
    localparam int CNT_W = $clog2(MAX_EVALS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic spent
);

    logic [CNT_W-1:0] used_q;

    assign spent = (used_q == CNT_W'(MAX_EVALS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            used_q <= '0;
        end else if (clr) begin
            used_q <= '0;
        end else if (inc && !spent) begin
            used_q <= used_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/delta_settle_ctrl.sv
module delta_settle_ctrl #(
    parameter int N_ENT     = 8,
    parameter int OUT_W     = 16,
    parameter int DEPTH_W   = 4,
    parameter int MAX_EVALS = 64,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1,
    localparam int REP_W = $clog2(MAX_EVALS + 1) + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [1:0]             stop_mode,
    input  logic [DEPTH_W-1:0]     cfg_depth,
    input  logic [N_ENT*N_ENT-1:0] cfg_fanout,
    output logic                   eval_go,
    output logic [IDX_W-1:0]       eval_idx,
    input  logic                   eval_done,
    input  logic                   link_changed,
    input  logic [OUT_W-1:0]       eval_out,
    output logic                   cycle_done,
    output logic                   swap_req,
    output logic                   budget_err
);
    import dsc_pkg::*;

    ctrl_state_e       state_q, state_d;
    logic [N_ENT-1:0]  pending_q;
    logic [IDX_W-1:0]  cur_q;
    logic [REP_W-1:0]  rep_q;
    logic              chg_q;
    logic [OUT_W-1:0]  prev_q;
    logic              err_q;

    logic              pick_any;
    logic [IDX_W-1:0]  pick_idx;
    logic              settled;
    logic              spent;
    logic              budget_clr;
    logic [N_ENT-1:0]  fan_row;

    dsc_pick_lowest #(.N_ENT(N_ENT)) u_pick (
        .req (pending_q),
        .any (pick_any),
        .idx (pick_idx)
    );

    dsc_settle_judge #(.OUT_W(OUT_W), .DEPTH_W(DEPTH_W), .REP_W(REP_W)) u_judge (
        .mode     (stop_mode),
        .depth    (cfg_depth),
        .reps     (rep_q),
        .cur_out  (eval_out),
        .prev_out (prev_q),
        .settled  (settled)
    );

    assign budget_clr = (state_q == S_IDLE) && start;

    dsc_eval_budget #(.MAX_EVALS(MAX_EVALS)) u_budget (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (budget_clr),
        .inc   (eval_go),
        .spent (spent)
    );

    assign fan_row = cfg_fanout[cur_q*N_ENT +: N_ENT];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = S_PICK;
            S_PICK:  state_d = pick_any ? S_ISSUE : S_DONE;
            S_ISSUE: state_d = spent ? S_FAULT : S_WAIT;
            S_WAIT:  if (eval_done) state_d = settled ? S_PICK : S_ISSUE;
            S_DONE:  state_d = S_SWAP;
            S_SWAP:  state_d = S_IDLE;
            S_FAULT: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        eval_go    = 1'b0;
        cycle_done = 1'b0;
        swap_req   = 1'b0;
        unique case (state_q)
            S_ISSUE: eval_go    = !spent;
            S_DONE:  cycle_done = 1'b1;
            S_SWAP:  swap_req   = 1'b1;
            default: ;
        endcase
    end

    assign eval_idx   = cur_q;
    assign budget_err = err_q;

    // Datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending_q <= '0;
            cur_q     <= '0;
            rep_q     <= '0;
            chg_q     <= 1'b0;
            prev_q    <= '0;
            err_q     <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        pending_q <= '1;
                        err_q     <= 1'b0;
                    end
                end
                S_PICK: begin
                    if (pick_any) begin
                        cur_q               <= pick_idx;
                        pending_q[pick_idx] <= 1'b0;
                        rep_q               <= '0;
                        chg_q               <= 1'b0;
                    end
                end
                S_ISSUE: begin
                    if (!spent) rep_q <= rep_q + REP_W'(1);
                end
                S_WAIT: begin
                    if (eval_done) begin
                        prev_q <= eval_out;
                        chg_q  <= chg_q | link_changed;
                        if (settled && (chg_q || link_changed)) begin
                            pending_q <= pending_q | fan_row;
                        end
                    end
                end
                S_FAULT: begin
                    err_q     <= 1'b1;
                    pending_q <= '0;
                end
                default: ;
            endcase
        end
    end

    AST_GO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        eval_go |=> !eval_go); // R3

    AST_IDX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        eval_go |=> $stable(eval_idx)); // R2

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |=> !cycle_done); // R9

    AST_SWAP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |=> swap_req); // R9

    AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |-> (pending_q == '0)); // R8

    AST_SPENT_NO_GO: assert property (@(posedge clk) disable iff (!rst_n)
        spent |-> !eval_go); // R10

    AST_ERR_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        budget_err |-> !cycle_done); // R10

endmodule

// File: tb/delta_settle_ctrl_tb.sv
module delta_settle_ctrl_tb;

    localparam int N   = 8;
    localparam int OW  = 16;
    localparam int DW  = 4;
    localparam int MAXE = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [1:0]      stop_mode = 2'b00;
    logic [DW-1:0]   cfg_depth = '0;
    logic [N*N-1:0]  cfg_fanout = '0;
    logic            eval_go;
    logic [2:0]      eval_idx;
    logic            eval_done = 1'b0;
    logic            link_changed = 1'b0;
    logic [OW-1:0]   eval_out = '0;
    logic            cycle_done;
    logic            swap_req;
    logic            budget_err;

    always #2 clk = ~clk; // 250 MHz

    delta_settle_ctrl #(.N_ENT(N), .OUT_W(OW), .DEPTH_W(DW), .MAX_EVALS(MAXE)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .stop_mode(stop_mode),
        .cfg_depth(cfg_depth), .cfg_fanout(cfg_fanout), .eval_go(eval_go),
        .eval_idx(eval_idx), .eval_done(eval_done), .link_changed(link_changed),
        .eval_out(eval_out), .cycle_done(cycle_done), .swap_req(swap_req),
        .budget_err(budget_err)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // evaluation unit model settings
    int settle_at [N];
    bit chg_once  [N];
    bit chg_always[N];
    int rc        [N];

    int log_idx [512];
    int log_n;
    int exp_idx [512];
    int exp_n;

    int cyc = 0;
    int done_cnt, swap_cnt, done_cyc, swap_cyc, go_viol;
    bit pend_resp = 0;
    bit go_prev = 0;
    int resp_idx;

    always @(negedge clk) begin
        cyc++;
        eval_done    = 1'b0;
        link_changed = 1'b0;
        if (eval_go && (go_prev || pend_resp)) go_viol++;
        go_prev = eval_go;
        if (cycle_done) begin done_cnt++; done_cyc = cyc; end
        if (swap_req)   begin swap_cnt++; swap_cyc = cyc; end
        if (pend_resp) begin
            rc[resp_idx]++;
            eval_done    = 1'b1;
            eval_out     = OW'((rc[resp_idx] < settle_at[resp_idx]) ? rc[resp_idx] : settle_at[resp_idx]);
            link_changed = chg_always[resp_idx] || (chg_once[resp_idx] && rc[resp_idx] == 1);
            pend_resp    = 0;
        end else if (eval_go) begin
            if (log_n < 512) log_idx[log_n] = int'(eval_idx);
            log_n++;
            resp_idx  = int'(eval_idx);
            pend_resp = 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int i = 0; i < N; i++) begin
            settle_at[i] = 0; chg_once[i] = 0; chg_always[i] = 0; rc[i] = 0;
        end
        log_n = 0; exp_n = 0;
        done_cnt = 0; swap_cnt = 0; done_cyc = -1; swap_cyc = -1; go_viol = 0;
        cfg_fanout = '0;
    endtask

    task automatic push_exp(input int idx, input int times);
        for (int k = 0; k < times; k++) begin
            exp_idx[exp_n] = idx;
            exp_n++;
        end
    endtask

    task automatic check_seq(input string req);
        int bad;
        bad = -1;
        for (int i = 0; i < exp_n && i < log_n; i++)
            if (bad < 0 && log_idx[i] != exp_idx[i]) bad = i;
        chk(log_n == exp_n, req, log_n, exp_n);
        if (bad >= 0) chk(0, req, log_idx[bad], exp_idx[bad]);
        else          chk(1, req, 0, 0);
    endtask

    task automatic run_cycle(input bit extra_start);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (extra_start) begin
            repeat (5) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        for (int t = 0; t < 3000; t++) begin
            @(negedge clk);
            if (done_cnt > 0 || budget_err) break;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(eval_go == 0 && cycle_done == 0 && swap_req == 0, "R1", int'(eval_go), 0);
        chk(budget_err == 0 && eval_idx == 0, "R1", int'(budget_err), 0);
    endtask

    // count mode depth 2, no link changes, a stray start mid-run
    task automatic t_count();
        clear_model();
        stop_mode = 2'b00; cfg_depth = 4'd2;
        for (int i = 0; i < N; i++) push_exp(i, 2);
        run_cycle(1);
        check_seq("R4/R2/R11");
        chk(done_cnt == 1, "R8", done_cnt, 1);
        chk(swap_cnt == 1 && swap_cyc == done_cyc + 1, "R9", swap_cyc, done_cyc + 1);
        chk(go_viol == 0, "R3", go_viol, 0);
    endtask

    task automatic t_depth_zero();
        clear_model();
        stop_mode = 2'b00; cfg_depth = 4'd0;
        for (int i = 0; i < N; i++) push_exp(i, 1);
        run_cycle(0);
        check_seq("R4 depth0");
        chk(done_cnt == 1, "R8", done_cnt, 1);
    endtask

    function automatic int match_evals(input int s);
        return (s == 0) ? 2 : s + 1;
    endfunction

    task automatic t_match();
        clear_model();
        stop_mode = 2'b01; cfg_depth = 4'd1;
        for (int i = 0; i < N; i++) begin
            settle_at[i] = i % 3;
            push_exp(i, match_evals(i % 3));
        end
        run_cycle(0);
        check_seq("R5");
        chk(go_viol == 0, "R3", go_viol, 0);
    endtask

    task automatic t_either();
        int e;
        clear_model();
        stop_mode = 2'b10; cfg_depth = 4'd3;
        for (int i = 0; i < N; i++) begin
            settle_at[i] = i % 4;
            e = match_evals(i % 4);
            push_exp(i, (e < 3) ? e : 3);
        end
        run_cycle(0);
        check_seq("R6");
        chk(done_cnt == 1 && swap_cnt == 1, "R9", swap_cnt, 1);
    endtask

    task automatic t_fanout();
        int seq [10] = '{0, 1, 2, 0, 3, 4, 5, 6, 3, 7};
        clear_model();
        stop_mode = 2'b00; cfg_depth = 4'd1;
        chg_once[2] = 1; chg_once[6] = 1;
        cfg_fanout[2*N + 0] = 1'b1;
        cfg_fanout[2*N + 5] = 1'b1;
        cfg_fanout[6*N + 3] = 1'b1;
        cfg_fanout[4*N + 1] = 1'b1; // entity 4 never changes: no effect (R8)
        foreach (seq[i]) push_exp(seq[i], 1);
        run_cycle(0);
        check_seq("R7/R8");
        chk(done_cnt == 1, "R8", done_cnt, 1);
    endtask

    task automatic t_budget();
        clear_model();
        stop_mode = 2'b00; cfg_depth = 4'd1;
        chg_always[0] = 1;
        cfg_fanout[0] = 1'b1;
        push_exp(0, MAXE);
        run_cycle(0);
        check_seq("R10");
        chk(budget_err == 1, "R10", int'(budget_err), 1);
        chk(done_cnt == 0 && swap_cnt == 0, "R10", done_cnt, 0);
        // next clean start clears the error
        clear_model();
        cfg_depth = 4'd1;
        for (int i = 0; i < N; i++) push_exp(i, 1);
        run_cycle(0);
        chk(budget_err == 0, "R10 clear", int'(budget_err), 0);
        check_seq("R10 clear");
        chk(done_cnt == 1, "R10 clear", done_cnt, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_count();
        t_depth_zero();
        t_match();
        t_either();
        t_fanout();
        t_budget();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule